// File: doc/BRIEF.md
# Three-Channel Interval Timer with Speaker Gate

This block holds three independent 16-bit down counters. All three advance on the same count enable (`tick`), which is qualified by the system clock. Software reaches them through four byte-wide ports. Offsets 0, 1 and 2 load and read counters 0, 1 and 2. Offset 3 takes a control word that programs one counter or freezes its count for a stable read. Each counter has three settings: an operating mode, a byte-sequencing mode for its port, and a choice of binary or packed-BCD counting.

Three operating modes are supported:
- **Terminal count:** the output goes low on a load and rises once the count has run out.
- **Rate generator:** one low tick per period.
- **Square wave:** the high half is rounded up.

The mode field in the control word is decoded from its three bits: codes 2 and 6 select the rate generator, codes 3 and 7 select the square wave, and every other code falls back to terminal count. A loaded value of zero stands for the full range of the count.

A two-bit auxiliary register sits beside the counters. Its low bit is the count gate of counter 2 and its high bit routes counter 2's output to the speaker line. A host typically writes the divisor for a tone, rounded as (1193182 + f/2)/f, low byte first, and then sets both auxiliary bits to sound the speaker.

Top module: `intv_timer`

## Requirements
- R1: After reset, `cntOut` is 000, `spkOut` is 0, the auxiliary register is 00, and `rdData` is 0.
- R2: A write to offset 3 is a control word with the following fields:
  - bits 7:6 select the counter (00, 01 or 10); a control word with select value 11 changes no counter.
  - bits 5:4 select the access: 00 latch, 01 low byte only, 10 high byte only, 11 low then high.
  - bits 3:1 select the mode.
  - bit 0 selects BCD counting.
- R3: In terminal-count mode the output is low from the load. It rises on the (N+1)th ticking edge after the edge that wrote the last byte of count N, and then stays high.
- R4: In rate-generator mode the output repeats with a period of N ticks and is low for exactly one tick of each period.
- R5: In square-wave mode the output is high for ceil(N/2) ticks and low for floor(N/2) ticks, reloading N by itself.
- R6: Byte sequencing depends on the access setting. Low-only loads the written byte as the low byte with the high byte zero, and reads return the low byte. High-only loads the written byte as the high byte with the low byte zero, and reads return the high byte. Low-then-high alternates one per-counter byte toggle for both reads and writes. Any non-latch control word resets that toggle to the low byte.
- R7: A loaded value of 0 counts as 65536 in binary and as 10000 in BCD.
- R8: With bit 0 of the control word set, the counter counts in packed BCD: each nibble is one decimal digit.
- R9: A latch command (access 00) captures the selected counter's count at that edge. Reads return the captured value until its last byte has been read. Counting carries on meanwhile.
- R10: Auxiliary bit 0 gates counter 2: while it is 0, counter 2 does not count and its output holds. `spkOut` is high only while both auxiliary bits are 1 and counter 2's output is high.
- R11: Counters change state only on cycles where `tick` is high. With `tick` low and no control write, no output changes.
- R12: A read of offset 3 returns 0. `rdData` is 0 whenever `rdEn` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Count enable shared by all counters |
| wrEn | input | 1 | Byte write strobe for the counter/control ports |
| rdEn | input | 1 | Byte read strobe; ignored while wrEn is high |
| addr | input | 2 | Port offset: 0-2 counters, 3 control word |
| wrData | input | 8 | Write byte |
| rdData | output | 8 | Read byte, valid in the cycle rdEn is high |
| auxWr | input | 1 | Write strobe for the auxiliary register |
| auxData | input | 2 | Auxiliary value: bit 0 counter 2 gate, bit 1 speaker enable |
| cntOut | output | 3 | Counter outputs, bit i for counter i |
| spkOut | output | 1 | Speaker drive |

## Verification
**Write timing.** A byte write is sampled on the edge following its strobe. That edge only arms the new count: the count register takes the value on the next ticking edge. A terminal-count output therefore rises N+1 ticking edges after the write edge, and the bench counts exactly that many falling clock edges before sampling the output.

**Read timing.** `rdData` is combinational in the strobe cycle and is sampled 1 ns after the strobe is driven. The byte toggle and the latch release move on the following edge.

**Periodic outputs.** These are judged over windows that are whole multiples of the period, sampled on falling edges. The number of high samples and falling transitions in such a window is then exact regardless of phase.

**Latch values.** These are derived from the number of edges between the load edge and the latch edge.

// File: rtl/intv_timer_pkg.sv
package intv_timer_pkg;
  localparam int NUM_CNT = 3;
  localparam int BYTE_W  = 8;
  localparam int CNT_W   = 16;
  localparam int EXT_W   = CNT_W + 1;
  localparam int DIGITS  = CNT_W / 4;
  localparam int ADDR_W  = 2;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 2'd3;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_BOTH  = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    RUN_TERM   = 2'd0,
    RUN_RATE   = 2'd1,
    RUN_SQUARE = 2'd2
  } run_e;

  // strobes from the decoder to the counter bank
  typedef struct packed {
    logic [NUM_CNT-1:0] setMode;
    logic [NUM_CNT-1:0] latch;
    logic [NUM_CNT-1:0] wrByte;
    logic [NUM_CNT-1:0] rdByte;
    logic [BYTE_W-1:0]  data;
  } tmrStb_t;

  // one step down; the extended top bit is a fifth digit limited to 0/1
  function automatic logic [EXT_W-1:0] decVal(input logic [EXT_W-1:0] v, input logic bcd);
    logic [EXT_W-1:0] r;
    logic borrow;
    r = v;
    borrow = 1'b1;
    if (!bcd) begin
      r = v - 1'b1;
    end else begin
      for (int i = 0; i < DIGITS; i++) begin
        if (borrow) begin
          if (v[4*i +: 4] == 4'd0) begin
            r[4*i +: 4] = 4'd9;
          end else begin
            r[4*i +: 4] = v[4*i +: 4] - 4'd1;
            borrow = 1'b0;
          end
        end
      end
      if (borrow) r[EXT_W-1] = ~v[EXT_W-1];
    end
    if (v == '0) r[EXT_W-1] = 1'b0;
    return r;
  endfunction

  // floor of half, binary or packed BCD
  function automatic logic [EXT_W-1:0] halfVal(input logic [EXT_W-1:0] v, input logic bcd);
    logic [EXT_W-1:0] r;
    logic carry;
    logic [4:0] t;
    if (!bcd) begin
      r = v >> 1;
    end else begin
      r = '0;
      carry = v[EXT_W-1];
      for (int i = DIGITS - 1; i >= 0; i--) begin
        t = {1'b0, v[4*i +: 4]} + (carry ? 5'd10 : 5'd0);
        r[4*i +: 4] = t[4:1];
        carry = t[0];
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/intv_timer_cnt.sv
module intv_timer_cnt
  import intv_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              gate,
  input  logic              setMode,
  input  logic              latchCmd,
  input  logic              wrByte,
  input  logic              rdByte,
  input  logic [BYTE_W-1:0] data,
  output logic [BYTE_W-1:0] rdVal,
  output logic              outBit
);
  localparam logic [EXT_W-1:0] ONE_X  = EXT_W'(1);
  localparam logic [EXT_W-1:0] FULL_X = {1'b1, {CNT_W{1'b0}}};

  acc_e              accQ;
  run_e              runQ;
  logic              bcdQ;
  logic              togQ;
  logic [BYTE_W-1:0] lowHold;
  logic [CNT_W-1:0]  loadVal;
  logic              loadPend;
  logic              armed;
  logic [EXT_W-1:0]  ce;
  logic              latchQ;
  logic [CNT_W-1:0]  latchVal;
  logic              outQ;

  logic [EXT_W-1:0]  eff, half, nxt;
  logic [CNT_W-1:0]  srcVal;
  logic [CNT_W-1:0]  newVal;
  logic              partial;
  run_e              runDec;

  always_comb begin
    eff    = (loadVal == '0) ? FULL_X : {1'b0, loadVal};
    half   = halfVal(eff, bcdQ);
    nxt    = decVal(ce, bcdQ);
    srcVal = latchQ ? latchVal : ce[CNT_W-1:0];
    case (accQ)
      ACC_LO:  rdVal = srcVal[BYTE_W-1:0];
      ACC_HI:  rdVal = srcVal[CNT_W-1 -: BYTE_W];
      default: rdVal = togQ ? srcVal[CNT_W-1 -: BYTE_W] : srcVal[BYTE_W-1:0];
    endcase
    partial = 1'b0;
    case (accQ)
      ACC_LO:  newVal = {{(CNT_W-BYTE_W){1'b0}}, data};
      ACC_HI:  newVal = {data, {(CNT_W-BYTE_W){1'b0}}};
      default: begin
        newVal  = {data, lowHold};
        partial = !togQ;
      end
    endcase
    case (data[3:1])
      3'b010, 3'b110: runDec = RUN_RATE;
      3'b011, 3'b111: runDec = RUN_SQUARE;
      default:        runDec = RUN_TERM;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ     <= ACC_BOTH;
      runQ     <= RUN_TERM;
      bcdQ     <= 1'b0;
      togQ     <= 1'b0;
      lowHold  <= '0;
      loadVal  <= '0;
      loadPend <= 1'b0;
      armed    <= 1'b0;
      ce       <= '0;
      latchQ   <= 1'b0;
      latchVal <= '0;
      outQ     <= 1'b0;
    end else begin
      if (tick && gate) begin
        if (loadPend) begin
          ce       <= eff;
          armed    <= 1'b1;
          loadPend <= 1'b0;
          outQ     <= (runQ == RUN_TERM) ? 1'b0 :
                      (runQ == RUN_RATE) ? (eff != ONE_X) : 1'b1;
        end else if (armed) begin
          case (runQ)
            RUN_RATE: begin
              if (ce == ONE_X) begin
                ce   <= eff;
                outQ <= 1'b1;
              end else begin
                ce   <= nxt;
                outQ <= (nxt != ONE_X);
              end
            end
            RUN_SQUARE: begin
              if (ce == ONE_X) begin
                ce   <= eff;
                outQ <= 1'b1;
              end else begin
                ce   <= nxt;
                outQ <= (nxt > half);
              end
            end
            default: begin
              ce   <= nxt;
              outQ <= outQ | (ce == ONE_X);
            end
          endcase
        end
      end
      if (wrByte) begin
        if (partial) begin
          lowHold <= data;
          togQ    <= 1'b1;
        end else begin
          loadVal  <= newVal;
          loadPend <= 1'b1;
          if (accQ == ACC_BOTH) togQ <= 1'b0;
          if (runQ == RUN_TERM) outQ <= 1'b0;
        end
      end
      if (rdByte) begin
        if (accQ == ACC_BOTH) togQ <= ~togQ;
        if (accQ != ACC_BOTH || togQ) latchQ <= 1'b0;
      end
      if (latchCmd && !latchQ) begin
        latchQ   <= 1'b1;
        latchVal <= ce[CNT_W-1:0];
      end
      if (setMode) begin
        accQ     <= acc_e'(data[5:4]);
        runQ     <= runDec;
        bcdQ     <= data[0];
        togQ     <= 1'b0;
        armed    <= 1'b0;
        loadPend <= 1'b0;
        outQ     <= (runDec != RUN_TERM);
      end
    end
  end

  assign outBit = outQ;
endmodule

// File: rtl/intv_timer_dp.sv
module intv_timer_dp
  import intv_timer_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  logic               gate2,
  input  tmrStb_t            stb,
  output logic [BYTE_W-1:0]  rdBytes [NUM_CNT],
  output logic [NUM_CNT-1:0] cntOut
);
  for (genvar i = 0; i < NUM_CNT; i++) begin : gCnt
    logic gateI;
    if (i == NUM_CNT - 1) begin : gGated
      assign gateI = gate2;
    end else begin : gFree
      assign gateI = 1'b1;
    end
    intv_timer_cnt uCnt (
      .clk     (clk),
      .rstN    (rstN),
      .tick    (tick),
      .gate    (gateI),
      .setMode (stb.setMode[i]),
      .latchCmd(stb.latch[i]),
      .wrByte  (stb.wrByte[i]),
      .rdByte  (stb.rdByte[i]),
      .data    (stb.data),
      .rdVal   (rdBytes[i]),
      .outBit  (cntOut[i])
    );
  end
endmodule

// File: rtl/intv_timer_ctl.sv
module intv_timer_ctl
  import intv_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              auxWr,
  input  logic [1:0]        auxData,
  input  logic [BYTE_W-1:0] rdBytes [NUM_CNT],
  output tmrStb_t           stb,
  output logic [BYTE_W-1:0] rdData,
  output logic [1:0]        auxQ
);
  logic ctrlWr, rdGo;
  logic [BYTE_W-1:0] byteSel;

  assign ctrlWr = wrEn && (addr == CTRL_ADDR);
  assign rdGo   = rdEn && !wrEn;

  always_comb begin
    stb      = '0;
    stb.data = wrData;
    byteSel  = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      stb.setMode[i] = ctrlWr && (wrData[7:6] == 2'(i)) && (wrData[5:4] != ACC_LATCH);
      stb.latch[i]   = ctrlWr && (wrData[7:6] == 2'(i)) && (wrData[5:4] == ACC_LATCH);
      stb.wrByte[i]  = wrEn && (addr == 2'(i));
      stb.rdByte[i]  = rdGo && (addr == 2'(i));
      if (addr == 2'(i)) byteSel = rdBytes[i];
    end
    rdData = rdGo ? byteSel : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)      auxQ <= 2'b00;
    else if (auxWr) auxQ <= auxData;
  end
endmodule

// File: rtl/intv_timer.sv
module intv_timer
  import intv_timer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [1:0]  addr,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData,
  input  logic        auxWr,
  input  logic [1:0]  auxData,
  output logic [2:0]  cntOut,
  output logic        spkOut
);
  tmrStb_t           stb;
  logic [BYTE_W-1:0] rdBytes [NUM_CNT];
  logic [1:0]        auxQ;

  intv_timer_ctl uCtl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .addr   (addr),
    .wrData (wrData),
    .auxWr  (auxWr),
    .auxData(auxData),
    .rdBytes(rdBytes),
    .stb    (stb),
    .rdData (rdData),
    .auxQ   (auxQ)
  );

  intv_timer_dp uDp (
    .clk    (clk),
    .rstN   (rstN),
    .tick   (tick),
    .gate2  (auxQ[0]),
    .stb    (stb),
    .rdBytes(rdBytes),
    .cntOut (cntOut)
  );

  assign spkOut = cntOut[NUM_CNT-1] & auxQ[1] & auxQ[0];
endmodule

// File: rtl/intv_timer_chk.sv
module intv_timer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       tick,
  input logic       wrEn,
  input logic       rdEn,
  input logic [1:0] addr,
  input logic [7:0] rdData,
  input logic [1:0] auxQ,
  input logic [2:0] cntOut,
  input logic       spkOut
);
  a_r11_no_tick_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !wrEn) |=> $stable(cntOut));

  a_r10_gate_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!auxQ[0] && !wrEn) |=> $stable(cntOut[2]));

  a_r10_spk_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!auxQ[1]) |-> !spkOut);

  a_r12_ctrl_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && addr == 2'd3) |-> (rdData == 8'h00));

  a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    (!rdEn) |-> (rdData == 8'h00));
endmodule

bind intv_timer intv_timer_chk u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .tick  (tick),
  .wrEn  (wrEn),
  .rdEn  (rdEn),
  .addr  (addr),
  .rdData(rdData),
  .auxQ  (auxQ),
  .cntOut(cntOut),
  .spkOut(spkOut)
);

// File: tb/sim_intv_timer.sv
module sim_intv_timer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b1;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       auxWr = 1'b0;
  logic [1:0] auxData = 2'b00;
  logic [2:0] cntOut;
  logic       spkOut;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  intv_timer u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .auxWr(auxWr),
    .auxData(auxData), .cntOut(cntOut), .spkOut(spkOut)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wrPort(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdPort(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic wrAux(input logic [1:0] v);
    @(negedge clk);
    auxData = v; auxWr = 1'b1;
    @(negedge clk);
    auxWr = 1'b0;
  endtask

  // sel 0..2 counter output, 3 speaker; div toggles tick each cycle
  task automatic win(input int sel, input int n, input bit div, output int hi, output int falls);
    logic prev, v;
    hi = 0; falls = 0;
    prev = (sel == 3) ? spkOut : cntOut[sel];
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (div) tick = ~tick;
      #1 v = (sel == 3) ? spkOut : cntOut[sel];
      if (v) hi++;
      if (prev && !v) falls++;
      prev = v;
    end
  endtask

  // terminal-count rise: low after n edges, high after n+1
  task automatic termRise(input string req, input int sel, input int n);
    repeat (n) @(negedge clk);
    chk(req, int'(cntOut[sel]), 0);
    @(negedge clk);
    chk(req, int'(cntOut[sel]), 1);
  endtask

  task automatic readWord(input logic [1:0] a, output int val);
    logic [7:0] lo, hi;
    rdPort(a, lo);
    rdPort(a, hi);
    val = {16'h0, hi, lo};
  endtask

  task automatic t_reset();
    chk("R1 cntOut", int'(cntOut), 0);
    chk("R1 spkOut", int'(spkOut), 0);
    chk("R1 rdData", int'(rdData), 0);
  endtask

  task automatic t_term_lsb();
    wrPort(3, 8'h10); wrPort(0, 8'h07);
    termRise("R3 R6 lsb N=7", 0, 7);
    repeat (40) @(negedge clk);
    chk("R3 sticky high", int'(cntOut[0]), 1);
  endtask

  task automatic t_msb_latch();
    logic [7:0] d;
    wrPort(3, 8'h20); wrPort(0, 8'h03);
    repeat (2) @(negedge clk);
    wrPort(3, 8'h00);
    rdPort(0, d);
    chk("R6 msb read", int'(d), 8'h02);
  endtask

  task automatic t_bcd_term();
    wrPort(3, 8'h11); wrPort(0, 8'h10);
    termRise("R8 bcd N=10", 0, 10);
  endtask

  task automatic t_zero();
    wrPort(3, 8'h10); wrPort(0, 8'h00);
    termRise("R7 binary zero", 0, 65536);
    wrPort(3, 8'h11); wrPort(0, 8'h00);
    termRise("R7 bcd zero", 0, 10000);
  endtask

  task automatic t_rate();
    int hi, fl;
    wrPort(3, 8'h34); wrPort(0, 8'h04); wrPort(0, 8'h00);
    repeat (3) @(negedge clk);
    win(0, 40, 1'b0, hi, fl);
    chk("R4 rate highs", hi, 30);
    chk("R4 rate periods", fl, 10);
  endtask

  task automatic t_tick();
    int hi, fl;
    win(0, 80, 1'b1, hi, fl);
    tick = 1'b1;
    chk("R11 half-rate highs", hi, 60);
    chk("R11 half-rate periods", fl, 10);
    tick = 1'b0;
    win(0, 20, 1'b0, hi, fl);
    chk("R11 no tick frozen", fl, 0);
    tick = 1'b1;
  endtask

  task automatic t_latch();
    logic [7:0] lo, hi;
    int live;
    wrPort(3, 8'h74); wrPort(1, 8'hE8); wrPort(1, 8'h03);
    repeat (10) @(negedge clk);
    wrPort(3, 8'h40);
    repeat (20) @(negedge clk);
    rdPort(1, lo); rdPort(1, hi);
    chk("R9 latched low", int'(lo), 8'hDE);
    chk("R9 latched high", int'(hi), 8'h03);
    readWord(1, live);
    chk("R9 counting continued", int'(live < 990 && live > 900), 1);
  endtask

  task automatic t_toggle_reset();
    int hi, fl;
    wrPort(3, 8'h74); wrPort(1, 8'h99);
    wrPort(3, 8'h74); wrPort(1, 8'h10); wrPort(1, 8'h00);
    repeat (3) @(negedge clk);
    win(1, 64, 1'b0, hi, fl);
    chk("R6 toggle reset highs", hi, 60);
    chk("R6 toggle reset periods", fl, 4);
  endtask

  task automatic t_select3();
    int hi, fl;
    wrPort(3, 8'h74); wrPort(1, 8'h04); wrPort(1, 8'h00);
    wrPort(3, 8'hD6);
    repeat (3) @(negedge clk);
    win(1, 40, 1'b0, hi, fl);
    chk("R2 select 3 ignored highs", hi, 30);
    chk("R2 select 3 ignored periods", fl, 10);
  endtask

  task automatic t_square();
    int hi, fl;
    wrPort(3, 8'h76); wrPort(1, 8'h05); wrPort(1, 8'h00);
    repeat (3) @(negedge clk);
    win(1, 50, 1'b0, hi, fl);
    chk("R5 square N=5 highs", hi, 30);
    chk("R5 square N=5 periods", fl, 10);
    wrPort(3, 8'h77); wrPort(1, 8'h15); wrPort(1, 8'h00);
    repeat (3) @(negedge clk);
    win(1, 60, 1'b0, hi, fl);
    chk("R8 R5 bcd square 15 highs", hi, 32);
    chk("R8 bcd square 15 periods", fl, 4);
  endtask

  task automatic t_ctrl_read();
    logic [7:0] d;
    rdPort(3, d);
    chk("R12 control read", int'(d), 0);
    #2 chk("R12 idle rdData", int'(rdData), 0);
  endtask

  task automatic t_speaker();
    int hi, fl, v1, v2;
    wrPort(3, 8'hB6); wrPort(2, 8'h04); wrPort(2, 8'h00);
    repeat (5) @(negedge clk);
    chk("R10 gate off no load", int'(cntOut[2]), 1);
    wrAux(2'b11);
    repeat (4) @(negedge clk);
    win(3, 40, 1'b0, hi, fl);
    chk("R10 speaker highs", hi, 20);
    chk("R10 speaker periods", fl, 10);
    wrAux(2'b01);
    win(3, 20, 1'b0, hi, fl);
    chk("R10 speaker muted", hi, 0);
    win(2, 20, 1'b0, hi, fl);
    chk("R10 counter 2 runs", fl, 5);
    wrAux(2'b10);
    win(2, 20, 1'b0, hi, fl);
    chk("R10 gate off paused", fl, 0);
    wrPort(3, 8'h80); readWord(2, v1);
    repeat (5) @(negedge clk);
    wrPort(3, 8'h80); readWord(2, v2);
    chk("R10 R9 paused count", v2, v1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl_read();
    t_term_lsb();
    t_msb_latch();
    t_bcd_term();
    t_rate();
    t_tick();
    t_latch();
    t_toggle_reset();
    t_select3();
    t_square();
    t_speaker();
    t_zero();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule